// File: doc/BRIEF.md
# Floating-Point Compare Predicate Unit

This block compares two IEEE-754 operands, either both single or both double precision, and reduces the comparison to one boolean answer. A three-bit predicate code selects the answer. Three predicates are ordered: equal, less, and less-or-equal. Four are unordered: the plain unordered test, and the unordered-or-equal, unordered-or-less and unordered-or-less-or-equal tests. Alongside the answer the block reports a five-bit exception-flag vector. A comparison can only ever set the invalid-operation bit.

Requests enter on a valid/ready stream. Each request carries both operands, a precision select and the predicate code. Results leave on a second valid/ready stream one clock after acceptance. The output stage is a single register. While the consumer holds `out_ready` low and a result is waiting, `in_ready` is low, and the waiting result stays frozen until it is taken. When the stage is empty, or is being emptied in the same cycle, a new request is accepted.

Top module: `fcmp_unit`

## Requirements
- R1: `in_ready` equals `!out_valid || out_ready`. A request accepted on a clock edge (`in_valid && in_ready`) appears with `out_valid` high after that edge. A result whose `out_valid` is high and whose `out_ready` is low holds `out_res` and `out_flags` unchanged until it is taken.
- R2: After reset, `out_valid` is low and `in_ready` is high.
- R3: With `in_dbl` low, the operands are binary32 values in bits 31:0 and bits 63:32 have no effect. A value is NaN when its exponent is all ones and its fraction is nonzero. It is a signalling NaN when, in addition, the top fraction bit is 0.
- R4: Code 0 (unordered) is true exactly when at least one operand is NaN.
- R5: Code 1 (ordered equal) is true when neither operand is NaN and the values are equal. +0 and −0 are equal.
- R6: Code 2 (unordered or equal) is true when either operand is NaN or the values are equal.
- R7: Code 3 (ordered less) is true when neither operand is NaN and a < b. If either operand is any NaN, the result is false and invalid is raised.
- R8: Code 4 (unordered or less) is true when either operand is NaN or a < b.
- R9: Code 5 (ordered less-or-equal) is true when neither operand is NaN and a ≤ b. If either operand is any NaN, the result is false and invalid is raised.
- R10: Code 6 (unordered or less-or-equal) is false only when a > b with no NaN present.
- R11: Invalid is `out_flags[4]`. For codes 0, 1, 2, 4 and 6 it is set only if an operand is a signalling NaN. `out_flags[3:0]` are always 0.
- R12: Code 7 is reserved. It gives `out_res` = 0 and `out_flags` = 0.
- R13: Non-NaN values are ordered by sign, then by magnitude. Between two negative values the larger magnitude is the smaller value. Infinities sit at the ends of the order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be accepted |
| in_a | input | 64 | Left operand (single in bits 31:0) |
| in_b | input | 64 | Right operand (single in bits 31:0) |
| in_dbl | input | 1 | 1 = double precision, 0 = single |
| in_pred | input | 3 | Predicate code |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_res | output | 1 | Predicate answer |
| out_flags | output | 5 | Exception flags, bit 4 = invalid |

## Verification
The hardest situation to reach is a stalled result while a new request is already waiting. It is hardest when that request is a single-precision signalling NaN whose unused upper word holds bits that would look like a quiet NaN or a different number if read as a double. To reach it, the stimulus drops `out_ready` at random on about a third of cycles. It draws operands from pools of signed zeros, infinities, quiet and signalling NaNs and subnormals, fills the upper word of single operands with random bits, and often reuses the left operand as the right one so that equality cases are frequent. A queue-based model in the bench predicts `in_ready`, `out_valid` and every result on every clock.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
  typedef enum logic [2:0] {
    PR_UNORD = 3'd0,
    PR_OEQ   = 3'd1,
    PR_UEQ   = 3'd2,
    PR_OLT   = 3'd3,
    PR_ULT   = 3'd4,
    PR_OLE   = 3'd5,
    PR_ULE   = 3'd6,
    PR_RSV   = 3'd7
  } pred_e;

  localparam int FLAG_W       = 5;
  localparam int FLAG_INV_BIT = 4;
endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify #(
  parameter int SP_EXP  = 8,
  parameter int SP_FRAC = 23,
  parameter int DP_EXP  = 11,
  parameter int DP_FRAC = 52,
  localparam int DW     = 1 + DP_EXP + DP_FRAC,
  localparam int SW     = 1 + SP_EXP + SP_FRAC,
  localparam int MAG_W  = DP_EXP + DP_FRAC
) (
  input  logic [DW-1:0]    raw,
  input  logic             dbl,
  output logic             sign,
  output logic             zero,
  output logic             nan,
  output logic             snan,
  output logic [MAG_W-1:0] mag
);
  logic exp_ones, frac_nz, qbit;

  // Field extraction per precision; the magnitude is zero-extended so one
  // comparator downstream serves both formats.
  always_comb begin
    if (dbl) begin
      sign     = raw[DW-1];
      exp_ones = &raw[DW-2 -: DP_EXP];
      frac_nz  = |raw[DP_FRAC-1:0];
      qbit     = raw[DP_FRAC-1];
      mag      = raw[MAG_W-1:0];
    end else begin
      sign     = raw[SW-1];
      exp_ones = &raw[SW-2 -: SP_EXP];
      frac_nz  = |raw[SP_FRAC-1:0];
      qbit     = raw[SP_FRAC-1];
      mag      = MAG_W'(raw[SW-2:0]);
    end
  end

  assign nan  = exp_ones & frac_nz;
  assign snan = nan & ~qbit;
  assign zero = (mag == '0);
endmodule

// File: rtl/fcmp_relate.sv
module fcmp_relate #(
  parameter int MAG_W = 63
) (
  input  logic             a_sign,
  input  logic             a_zero,
  input  logic [MAG_W-1:0] a_mag,
  input  logic             b_sign,
  input  logic             b_zero,
  input  logic [MAG_W-1:0] b_mag,
  output logic             lt,
  output logic             eq
);
  // Sign-magnitude ordering; meaningless (and ignored) when a NaN is present.
  always_comb begin
    if (a_zero && b_zero) begin
      eq = 1'b1;
      lt = 1'b0;
    end else if (a_sign != b_sign) begin
      eq = 1'b0;
      lt = a_sign;
    end else begin
      eq = (a_mag == b_mag);
      lt = a_sign ? (a_mag > b_mag) : (a_mag < b_mag);
    end
  end
endmodule

// File: rtl/fcmp_predicate.sv
module fcmp_predicate
  import fcmp_pkg::*;
(
  input  pred_e pred,
  input  logic  nan_any,
  input  logic  snan_any,
  input  logic  lt,
  input  logic  eq,
  output logic  res,
  output logic  inv
);
  always_comb begin
    res = 1'b0;
    inv = snan_any;
    unique case (pred)
      PR_UNORD: res = nan_any;
      PR_OEQ:   res = ~nan_any & eq;
      PR_UEQ:   res = nan_any | eq;
      PR_OLT: begin
        res = ~nan_any & lt;
        inv = nan_any;
      end
      PR_ULT:   res = nan_any | lt;
      PR_OLE: begin
        res = ~nan_any & (lt | eq);
        inv = nan_any;
      end
      PR_ULE:   res = nan_any | lt | eq;
      default: begin
        res = 1'b0;
        inv = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/fcmp_unit.sv
module fcmp_unit
  import fcmp_pkg::*;
#(
  parameter int SP_EXP  = 8,
  parameter int SP_FRAC = 23,
  parameter int DP_EXP  = 11,
  parameter int DP_FRAC = 52,
  localparam int DW     = 1 + DP_EXP + DP_FRAC,
  localparam int MAG_W  = DP_EXP + DP_FRAC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DW-1:0]     in_a,
  input  logic [DW-1:0]     in_b,
  input  logic              in_dbl,
  input  logic [2:0]        in_pred,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_res,
  output logic [FLAG_W-1:0] out_flags
);
  logic             a_sign, a_zero, a_nan, a_snan;
  logic             b_sign, b_zero, b_nan, b_snan;
  logic [MAG_W-1:0] a_mag, b_mag;
  logic             lt, eq, res_c, inv_c, nan_any;
  logic [FLAG_W-1:0] flags_c;

  fcmp_classify #(.SP_EXP(SP_EXP), .SP_FRAC(SP_FRAC), .DP_EXP(DP_EXP), .DP_FRAC(DP_FRAC)) u_cls_a (
    .raw(in_a), .dbl(in_dbl), .sign(a_sign), .zero(a_zero), .nan(a_nan), .snan(a_snan), .mag(a_mag)
  );
  fcmp_classify #(.SP_EXP(SP_EXP), .SP_FRAC(SP_FRAC), .DP_EXP(DP_EXP), .DP_FRAC(DP_FRAC)) u_cls_b (
    .raw(in_b), .dbl(in_dbl), .sign(b_sign), .zero(b_zero), .nan(b_nan), .snan(b_snan), .mag(b_mag)
  );

  fcmp_relate #(.MAG_W(MAG_W)) u_rel (
    .a_sign(a_sign), .a_zero(a_zero), .a_mag(a_mag),
    .b_sign(b_sign), .b_zero(b_zero), .b_mag(b_mag),
    .lt(lt), .eq(eq)
  );

  assign nan_any = a_nan | b_nan;

  fcmp_predicate u_pred (
    .pred(pred_e'(in_pred)), .nan_any(nan_any), .snan_any(a_snan | b_snan),
    .lt(lt), .eq(eq), .res(res_c), .inv(inv_c)
  );

  always_comb begin
    flags_c = '0;
    flags_c[FLAG_INV_BIT] = inv_c;
  end

  // Single output register stage on a valid/ready stream.
  assign in_ready = ~out_valid | out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_res   <= 1'b0;
      out_flags <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_res   <= res_c;
        out_flags <= flags_c;
      end
    end
  end

  // R1
  hold_when_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_res) && $stable(out_flags));

  // R1
  accept_to_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R11
  only_invalid_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_flags[FLAG_INV_BIT-1:0] == '0);

  // R12
  reserved_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_pred == 3'd7 |=> !out_res && out_flags == '0);

  // R7
  olt_nan_signals_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_pred == 3'd3 && nan_any |=> !out_res && out_flags[FLAG_INV_BIT]);
endmodule

// File: tb/sim_fcmp_unit.sv
module sim_fcmp_unit;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 200000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready, in_dbl, out_valid, out_ready, out_res;
  logic [63:0] in_a, in_b;
  logic [2:0]  in_pred;
  logic [4:0]  out_flags;

  int total = 0;
  int bad   = 0;
  logic [5:0]  exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  fcmp_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_dbl(in_dbl), .in_pred(in_pred),
    .out_valid(out_valid), .out_ready(out_ready), .out_res(out_res), .out_flags(out_flags)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic string req_of(input logic [2:0] p);
    case (p)
      3'd0: return "R4 unordered";
      3'd1: return "R5 ordered-eq";
      3'd2: return "R6 unord-or-eq";
      3'd3: return "R7 ordered-lt";
      3'd4: return "R8 unord-or-lt";
      3'd5: return "R9 ordered-le";
      3'd6: return "R10 unord-or-le";
      default: return "R12 reserved";
    endcase
  endfunction

  // R3: binary32 in low word, NaN = exponent all ones and fraction nonzero
  function automatic logic is_nan(input logic [63:0] v, input logic dbl);
    if (dbl) return (v[62:52] == 11'h7ff) && (v[51:0] != 0);
    return (v[30:23] == 8'hff) && (v[22:0] != 0);
  endfunction

  function automatic logic is_snan(input logic [63:0] v, input logic dbl);
    return is_nan(v, dbl) && !(dbl ? v[51] : v[22]);
  endfunction

  function automatic real to_real(input logic [63:0] v, input logic dbl);
    real m;
    int  e;
    if (dbl) return $bitstoreal(v);
    e = int'(v[30:23]);
    if (e == 255)    m = 1.0e300;
    else if (e == 0) m = real'(v[22:0]) * (2.0 ** (-149));
    else             m = (1.0 + real'(v[22:0]) / 8388608.0) * (2.0 ** (e - 127));
    return v[31] ? -m : m;
  endfunction

  function automatic logic [5:0] ref_eval(input logic [63:0] a, input logic [63:0] b,
                                          input logic dbl, input logic [2:0] p);
    logic n, s, lt, eq, r, inv;
    real  ra, rb;
    n  = is_nan(a, dbl) || is_nan(b, dbl);
    s  = is_snan(a, dbl) || is_snan(b, dbl);
    ra = to_real(a, dbl);
    rb = to_real(b, dbl);
    lt = !n && (ra < rb);   // R13 numeric order
    eq = !n && (ra == rb);  // R5 +0 == -0 in reals
    inv = s;                // R11
    case (p)
      3'd0: r = n;
      3'd1: r = eq;
      3'd2: r = n || eq;
      3'd3: begin r = lt;       inv = n; end
      3'd4: r = n || lt;
      3'd5: begin r = lt || eq; inv = n; end
      3'd6: r = n || lt || eq;
      default: begin r = 1'b0; inv = 1'b0; end
    endcase
    return {r, inv, 4'b0000};
  endfunction

  // One clock: drive after the falling edge, check against the model, update it.
  task automatic step(input string tag, input logic v, input logic [63:0] a, input logic [63:0] b,
                      input logic dbl, input logic [2:0] p, input logic ordy);
    logic [5:0] e;
    @(negedge clk);
    in_valid = v; in_a = a; in_b = b; in_dbl = dbl; in_pred = p; out_ready = ordy;
    #1;
    check("R1 in_ready", in_ready, (exp_q.size() == 0) || ordy);
    check("R1 out_valid", out_valid, exp_q.size() != 0);
    if (out_valid && out_ready && exp_q.size() != 0) begin
      e = exp_q.pop_front();
      tag = tag_q.pop_front();
      check({tag, " result"}, out_res, e[5]);
      check({tag, " R11 flags"}, out_flags, e[4:0]);
    end
    if (v && in_ready) begin
      exp_q.push_back(ref_eval(a, b, dbl, p));
      tag_q.push_back(tag == "" ? req_of(p) : tag);
    end
  endtask

  function automatic logic [63:0] pick(input logic dbl);
    logic [63:0] d[12] = '{64'h0, 64'h8000_0000_0000_0000, 64'h3ff0_0000_0000_0000,
                           64'hbff0_0000_0000_0000, 64'h4000_0000_0000_0000, 64'hc000_0000_0000_0000,
                           64'h7ff0_0000_0000_0000, 64'hfff0_0000_0000_0000, 64'h7ff8_0000_0000_0000,
                           64'h7ff0_0000_0000_0001, 64'hfff4_0000_0000_0000, 64'h1};
    logic [31:0] s[12] = '{32'h0, 32'h8000_0000, 32'h3f80_0000, 32'hbf80_0000, 32'h4000_0000,
                           32'hc000_0000, 32'h7f80_0000, 32'hff80_0000, 32'h7fc0_0000,
                           32'h7f80_0001, 32'hffa0_0000, 32'h1};
    int k = int'($urandom % 16);
    if (dbl) return (k < 12) ? d[k] : {$urandom, $urandom};
    return {$urandom, (k < 12) ? s[k] : $urandom};
  endfunction

  initial begin : watchdog
    repeat (MAX_CYCLES) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [63:0] a, b;
    logic        dbl;
    void'($urandom(7));
    rst_n = 1'b0; in_valid = 1'b0; in_a = '0; in_b = '0; in_dbl = 1'b0; in_pred = '0; out_ready = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R2 reset out_valid", out_valid, 1'b0);
    check("R2 reset in_ready", in_ready, 1'b1);

    // directed corners
    step("R5 +0 eq -0 single", 1, 64'h0, 64'h8000_0000, 0, 3'd1, 1);
    step("R5 +0 eq -0 double", 1, 64'h8000_0000_0000_0000, 64'h0, 1, 3'd1, 1);
    step("R13 -2 lt -1", 1, 64'hc000_0000_0000_0000, 64'hbff0_0000_0000_0000, 1, 3'd3, 1);
    step("R13 -1 not lt -2", 1, 64'hbf80_0000, 64'hc000_0000, 0, 3'd3, 1);
    step("R7 qNaN signals", 1, 64'h7fc0_0000, 64'h3f80_0000, 0, 3'd3, 1);
    step("R9 qNaN signals", 1, 64'h3f80_0000, 64'h7fc0_0000, 0, 3'd5, 1);
    step("R11 qNaN quiet", 1, 64'h7ff8_0000_0000_0000, 64'h0, 1, 3'd0, 1);
    step("R11 sNaN invalid", 1, 64'h0, 64'h7f80_0001, 0, 3'd2, 1);
    step("R3 upper word ignored", 1, 64'h7ff8_0000_3f80_0000, 64'hffff_ffff_3f80_0000, 0, 3'd1, 1);
    step("R10 NaN true", 1, 64'hfff4_0000_0000_0000, 64'h1, 1, 3'd6, 1);
    step("R10 greater false", 1, 64'h4000_0000, 64'h3f80_0000, 0, 3'd6, 1);
    step("R8 -inf lt +inf", 1, 64'hff80_0000, 64'h7f80_0000, 0, 3'd4, 1);
    step("R12 reserved", 1, 64'h7f80_0001, 64'h7f80_0001, 0, 3'd7, 1);
    step("R1 stall", 1, 64'h3f80_0000, 64'h4000_0000, 0, 3'd3, 0);
    step("R1 stall hold", 1, 64'h4000_0000, 64'h3f80_0000, 0, 3'd3, 0);
    step("R1 release", 1, 64'h4000_0000, 64'h3f80_0000, 0, 3'd3, 1);
    step("R1 drain", 0, 64'h0, 64'h0, 0, 3'd0, 1);

    for (int i = 0; i < 4000; i++) begin
      dbl = $urandom % 2;
      a = pick(dbl);
      b = ($urandom % 4 == 0) ? a : pick(dbl);
      if (!dbl && ($urandom % 4 == 0)) b[63:32] = $urandom;  // R3 same low word, new upper word
      step("", ($urandom % 5) != 0, a, b, dbl, 3'($urandom), ($urandom % 3) != 0);
    end
    for (int i = 0; i < 4; i++) step("R1 drain", 0, 64'h0, 64'h0, 0, 3'd0, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule